// File: doc/BRIEF.md
# I2C Event Status Flag Controller

This block keeps the event and status flags of an I2C peripheral. A bus engine outside it reports what happens on the wires through single-cycle strobes: a start generated by this node, a start or stop seen on the bus, an own-address match, a finished byte, lost arbitration and a sent 10-bit header. The block also receives the transfer direction and the register-access strobes from the processor side. It turns all of these into one packed status byte, an interrupt request and a request to stretch SCL low.

Each flag is set by a hardware strobe and cleared by the access sequence that belongs to it. Several flags clear only through a two-step access: a status read followed by a data-register access of the right kind. A small sequencer tracks this access. In `ACC_IDLE` nothing is armed. A status read moves it to `ACC_ARMED` and records which of SB, BTF and ADD10 were set at that moment. A further status read in `ACC_ARMED` stays there and records the flags again. A data read or a data write in `ACC_ARMED` applies the matching clears and goes back to `ACC_IDLE`. Clearing the peripheral enable forces `ACC_IDLE` from either state. Disable, stop and arbitration loss each have their own hardware clear paths.

Top module: `i2c_evflag_ctrl`

## Requirements
- R1: `status_o` places SB at bit 0, master flag at bit 1, address-match at bit 2, BTF at bit 3, BUSY at bit 4, TRA at bit 5 and ADD10 at bit 6. Every flag is registered and shows in the cycle after the strobe that changes it.
- R2: SB and the master flag set on `start_gen_i`. SB clears on a data write that follows a status read taken while SB was set.
- R3: The master flag clears on `stop_det_i` or on `arb_lost_i`.
- R4: The address-match flag sets on `addr_match_i` and clears on `sts_rd_i` alone.
- R5: BTF sets on `byte_done_i`. When TRA is 1 it clears on a data write after an armed status read. When TRA is 0 it clears on a data read after an armed status read. The data access of the other kind leaves it set. `dma_done_i` clears it directly.
- R6: TRA loads `tx_dir_i` on `byte_done_i`. It clears whenever BTF clears, and also on a stop or on arbitration loss.
- R7: BUSY sets on `start_seen_i` and clears on `stop_det_i`, whether or not `pe_i` is high.
- R8: ADD10 sets on `hdr10_sent_i`. It clears on a data write after an armed status read, or on a stop.
- R9: While `pe_i` is 0, every flag except BUSY is forced to 0, their set strobes are ignored and the sequencer returns to `ACC_IDLE`.
- R10: The status read arms a clear only for flags that were set when the read happened. A data access with no status read before it clears nothing. Each status read is consumed by the first data access that follows it.
- R11: When a set strobe and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R12: Bit 7 of `status_o` is the OR of SB, address-match, BTF, ADD10, `stop_det_i` and `arb_lost_i`. `irq_o` is bit 7 ANDed with `ite_i`.
- R13: `scl_hold_o` is 1 exactly when SB, address-match or BTF is set.
- R14: After reset, all flags are 0 and the sequencer is in `ACC_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pe_i | input | 1 | Peripheral enable |
| ite_i | input | 1 | Interrupt enable |
| start_gen_i | input | 1 | Strobe: this node generated a start |
| start_seen_i | input | 1 | Strobe: start condition detected on the bus |
| stop_det_i | input | 1 | Strobe: stop condition detected on the bus |
| addr_match_i | input | 1 | Strobe: received address matched own or general call |
| byte_done_i | input | 1 | Strobe: byte finished, acknowledge pulse done |
| tx_dir_i | input | 1 | Direction of the finished byte, 1 = transmit |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| hdr10_sent_i | input | 1 | Strobe: 10-bit address header sent |
| sts_rd_i | input | 1 | Strobe: status register read |
| dat_rd_i | input | 1 | Strobe: data register read |
| dat_wr_i | input | 1 | Strobe: data register write |
| dma_done_i | input | 1 | Strobe: DMA transfer complete |
| status_o | output | 8 | Packed status byte |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
The bench covers these corner cases:

- A data write that has no status read before it. A design that arms without the read would drop SB here.
- The data access of the wrong kind for the current direction. A design that ignores TRA would clear BTF on a read while transmitting, or on a write while receiving.
- A flag raised after the status read but before the data write. A design that clears from the live flags, rather than from those recorded at the read, would lose ADD10.
- A byte finishing in the same cycle as its clearing read, and an address match arriving together with the status read. Both test that a set beats a clear.
- Disable while the sequencer is armed, followed by a fresh SB. A design that keeps the arming across disable would clear that SB on the next bare data write.
- Bus starts and stops while disabled. These must still move BUSY.

// File: rtl/i2c_evf_pkg.sv
package i2c_evf_pkg;
    localparam int unsigned FLAG_W  = 7;
    localparam int unsigned STS_W   = FLAG_W + 1;
    localparam int unsigned F_SB    = 0;
    localparam int unsigned F_MSL   = 1;
    localparam int unsigned F_ADSL  = 2;
    localparam int unsigned F_BTF   = 3;
    localparam int unsigned F_BUSY  = 4;
    localparam int unsigned F_TRA   = 5;
    localparam int unsigned F_ADD10 = 6;
    localparam int unsigned F_EVT   = FLAG_W;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_ARMED = 1'b1
    } acc_state_e;

    typedef struct packed {
        logic add10;
        logic btf;
        logic sb;
    } seen_t;
endpackage

// File: rtl/i2c_evf_cell.sv
module i2c_evf_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kill_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_q;

    // priority: kill, then set, then clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= RST_VAL;
        end else if (kill_i) begin
            q_q <= 1'b0;
        end else if (set_i) begin
            q_q <= 1'b1;
        end else if (clr_i) begin
            q_q <= 1'b0;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/i2c_evf_acc.sv
module i2c_evf_acc
    import i2c_evf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pe_i,
    input  logic sts_rd_i,
    input  logic dat_rd_i,
    input  logic dat_wr_i,
    input  logic sb_i,
    input  logic btf_i,
    input  logic add10_i,
    input  logic tra_i,
    output logic clr_sb_o,
    output logic clr_btf_o,
    output logic clr_add10_o
);
    acc_state_e state_q, state_d;
    seen_t      seen_q, seen_d;

    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (sts_rd_i) begin
                    state_d = ACC_ARMED;
                    seen_d  = '{add10: add10_i, btf: btf_i, sb: sb_i};
                end
            end
            ACC_ARMED: begin
                if (sts_rd_i) begin
                    seen_d = '{add10: add10_i, btf: btf_i, sb: sb_i};
                end else if (dat_rd_i || dat_wr_i) begin
                    state_d = ACC_IDLE;
                    seen_d  = '0;
                end
            end
            default: begin
                state_d = ACC_IDLE;
                seen_d  = '0;
            end
        endcase
        if (!pe_i) begin
            state_d = ACC_IDLE;
            seen_d  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ACC_IDLE;
            seen_q  <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    always_comb begin
        clr_sb_o    = 1'b0;
        clr_btf_o   = 1'b0;
        clr_add10_o = 1'b0;
        unique case (state_q)
            ACC_IDLE: ;
            ACC_ARMED: begin
                clr_sb_o    = dat_wr_i && seen_q.sb;
                clr_add10_o = dat_wr_i && seen_q.add10;
                clr_btf_o   = seen_q.btf && (tra_i ? dat_wr_i : dat_rd_i);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_evflag_ctrl.sv
module i2c_evflag_ctrl
    import i2c_evf_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pe_i,
    input  logic             ite_i,
    input  logic             start_gen_i,
    input  logic             start_seen_i,
    input  logic             stop_det_i,
    input  logic             addr_match_i,
    input  logic             byte_done_i,
    input  logic             tx_dir_i,
    input  logic             arb_lost_i,
    input  logic             hdr10_sent_i,
    input  logic             sts_rd_i,
    input  logic             dat_rd_i,
    input  logic             dat_wr_i,
    input  logic             dma_done_i,
    output logic [STS_W-1:0] status_o,
    output logic             irq_o,
    output logic             scl_hold_o
);
    logic [FLAG_W-1:0] set_v, clr_v, kill_v, flag_q;
    logic              clr_sb, clr_btf_acc, clr_add10, btf_drop, event_any;

    i2c_evf_acc u_acc (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pe_i        (pe_i),
        .sts_rd_i    (sts_rd_i),
        .dat_rd_i    (dat_rd_i),
        .dat_wr_i    (dat_wr_i),
        .sb_i        (flag_q[F_SB]),
        .btf_i       (flag_q[F_BTF]),
        .add10_i     (flag_q[F_ADD10]),
        .tra_i       (flag_q[F_TRA]),
        .clr_sb_o    (clr_sb),
        .clr_btf_o   (clr_btf_acc),
        .clr_add10_o (clr_add10)
    );

    assign btf_drop = clr_btf_acc || dma_done_i;

    always_comb begin
        set_v          = '0;
        clr_v          = '0;
        kill_v         = {FLAG_W{!pe_i}};
        kill_v[F_BUSY] = 1'b0;

        set_v[F_SB]    = start_gen_i;
        clr_v[F_SB]    = clr_sb;

        set_v[F_MSL]   = start_gen_i;
        clr_v[F_MSL]   = stop_det_i || arb_lost_i;

        set_v[F_ADSL]  = addr_match_i;
        clr_v[F_ADSL]  = sts_rd_i;

        set_v[F_BTF]   = byte_done_i;
        clr_v[F_BTF]   = btf_drop;

        set_v[F_BUSY]  = start_seen_i;
        clr_v[F_BUSY]  = stop_det_i;

        set_v[F_TRA]   = byte_done_i && tx_dir_i;
        clr_v[F_TRA]   = btf_drop || stop_det_i || arb_lost_i || (byte_done_i && !tx_dir_i);

        set_v[F_ADD10] = hdr10_sent_i;
        clr_v[F_ADD10] = clr_add10 || stop_det_i;
    end

    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        i2c_evf_cell #(.RST_VAL(1'b0)) u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .kill_i (kill_v[g]),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .q_o    (flag_q[g])
        );
    end

    assign event_any  = flag_q[F_SB] || flag_q[F_ADSL] || flag_q[F_BTF] ||
                        flag_q[F_ADD10] || stop_det_i || arb_lost_i;
    assign status_o   = {event_any, flag_q};
    assign irq_o      = event_any && ite_i;
    assign scl_hold_o = flag_q[F_SB] || flag_q[F_ADSL] || flag_q[F_BTF];
endmodule

// File: rtl/i2c_evf_chk.sv
module i2c_evf_chk
    import i2c_evf_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pe_i,
    input logic             ite_i,
    input logic             start_gen_i,
    input logic             start_seen_i,
    input logic             stop_det_i,
    input logic             addr_match_i,
    input logic             byte_done_i,
    input logic             sts_rd_i,
    input logic             dma_done_i,
    input logic [STS_W-1:0] status_o,
    input logic             irq_o,
    input logic             scl_hold_o
);
    a_r2_sb_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pe_i && start_gen_i |=> status_o[F_SB] && status_o[F_MSL]);

    a_r3_msl_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det_i && !start_gen_i |=> !status_o[F_MSL]);

    a_r4_adsl_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pe_i && sts_rd_i && !addr_match_i |=> !status_o[F_ADSL]);

    a_r5_dma_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pe_i && dma_done_i && !byte_done_i |=> !status_o[F_BTF] && !status_o[F_TRA]);

    a_r7_busy_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det_i && !start_seen_i |=> !status_o[F_BUSY]);

    a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pe_i |=> (status_o[FLAG_W-1:0] & ~(7'b1 << F_BUSY)) == '0);

    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pe_i && addr_match_i |=> status_o[F_ADSL]);

    a_r12_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ite_i && status_o[F_EVT]);

    a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[F_BTF] |-> scl_hold_o);
endmodule

bind i2c_evflag_ctrl i2c_evf_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pe_i         (pe_i),
    .ite_i        (ite_i),
    .start_gen_i  (start_gen_i),
    .start_seen_i (start_seen_i),
    .stop_det_i   (stop_det_i),
    .addr_match_i (addr_match_i),
    .byte_done_i  (byte_done_i),
    .sts_rd_i     (sts_rd_i),
    .dma_done_i   (dma_done_i),
    .status_o     (status_o),
    .irq_o        (irq_o),
    .scl_hold_o   (scl_hold_o)
);

// File: tb/i2c_evflag_ctrl_test.sv
module i2c_evflag_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pe, ite, sg, ss, sp, am, bd, tx, al, h10, sr, dr, dw, dma;
    logic [7:0] status;
    logic       irq, hold;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    i2c_evflag_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .pe_i(pe), .ite_i(ite),
        .start_gen_i(sg), .start_seen_i(ss), .stop_det_i(sp),
        .addr_match_i(am), .byte_done_i(bd), .tx_dir_i(tx),
        .arb_lost_i(al), .hdr10_sent_i(h10), .sts_rd_i(sr),
        .dat_rd_i(dr), .dat_wr_i(dw), .dma_done_i(dma),
        .status_o(status), .irq_o(irq), .scl_hold_o(hold)
    );

    // stim {pe ite | sg ss sp | am bd tx | al h10 | sr dr dw | dma},
    // expected flags {ADD10 TRA BUSY BTF ADSL MSL SB}, requirement tag
    localparam int NV = 42;
    localparam logic [25:0] VEC [NV] = '{
        {14'b11_000_000_00_000_0, 7'b0000000, 5'd14}, // R14 idle
        {14'b11_010_000_00_000_0, 7'b0010000, 5'd7},  // R7 busy
        {14'b11_100_000_00_000_0, 7'b0010011, 5'd2},  // R2 sb+msl
        {14'b11_000_000_00_001_0, 7'b0010011, 5'd10}, // R10 write w/o read
        {14'b11_000_000_00_100_0, 7'b0010011, 5'd10}, // R10 arm
        {14'b11_000_000_00_001_0, 7'b0010010, 5'd2},  // R2 sb clear
        {14'b11_000_000_01_000_0, 7'b1010010, 5'd8},  // R8 add10 set
        {14'b11_000_000_00_100_0, 7'b1010010, 5'd8},
        {14'b11_000_000_00_001_0, 7'b0010010, 5'd8},  // R8 add10 clear
        {14'b11_000_011_00_000_0, 7'b0111010, 5'd6},  // R6 tx byte
        {14'b11_000_000_00_100_0, 7'b0111010, 5'd5},
        {14'b11_000_000_00_010_0, 7'b0111010, 5'd5},  // R5 read in tx
        {14'b11_000_000_00_100_0, 7'b0111010, 5'd5},
        {14'b11_000_000_00_001_0, 7'b0010010, 5'd6},  // R6 tra follows btf
        {14'b11_000_010_00_000_0, 7'b0011010, 5'd5},  // R5 rx byte
        {14'b11_000_000_00_100_0, 7'b0011010, 5'd5},
        {14'b11_000_000_00_001_0, 7'b0011010, 5'd5},  // R5 write in rx
        {14'b11_000_000_00_100_0, 7'b0011010, 5'd5},
        {14'b11_000_000_00_010_0, 7'b0010010, 5'd5},  // R5 read clears rx
        {14'b11_000_000_10_000_0, 7'b0010000, 5'd3},  // R3 arb lost
        {14'b11_000_100_00_000_0, 7'b0010100, 5'd4},  // R4 match
        {14'b11_000_100_00_100_0, 7'b0010100, 5'd11}, // R11 set beats read
        {14'b11_000_000_00_100_0, 7'b0010000, 5'd4},  // R4 read clears
        {14'b11_000_011_00_000_0, 7'b0111000, 5'd6},
        {14'b11_000_000_00_000_1, 7'b0010000, 5'd5},  // R5 dma
        {14'b11_000_010_00_000_0, 7'b0011000, 5'd5},
        {14'b11_000_000_00_100_0, 7'b0011000, 5'd5},
        {14'b11_000_010_00_010_0, 7'b0011000, 5'd11}, // R11 byte beats read
        {14'b11_100_000_00_000_0, 7'b0011011, 5'd2},
        {14'b11_000_000_00_100_0, 7'b0011011, 5'd10},
        {14'b11_000_000_01_000_0, 7'b1011011, 5'd10}, // R10 set after read
        {14'b11_000_000_00_001_0, 7'b1011010, 5'd10}, // R10 only seen flags
        {14'b11_001_000_00_000_0, 7'b0001000, 5'd3},  // R3 stop
        {14'b10_000_000_00_000_0, 7'b0001000, 5'd12}, // R12 ite off
        {14'b01_000_000_00_000_0, 7'b0000000, 5'd9},  // R9 disable
        {14'b01_110_111_01_000_0, 7'b0010000, 5'd9},  // R9 sets ignored
        {14'b01_001_000_00_000_0, 7'b0000000, 5'd7},  // R7 stop while off
        {14'b11_100_000_00_000_0, 7'b0000011, 5'd1},  // R1 layout
        {14'b11_000_000_00_100_0, 7'b0000011, 5'd9},
        {14'b01_000_000_00_000_0, 7'b0000000, 5'd9},  // R9 disarm
        {14'b11_100_000_00_000_0, 7'b0000011, 5'd13}, // R13 hold
        {14'b11_000_000_00_001_0, 7'b0000011, 5'd9}   // R9 no stale arm
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [13:0] s);
        {pe, ite, sg, ss, sp, am, bd, tx, al, h10, sr, dr, dw, dma} = s;
    endtask

    initial begin
        drive('0);
        repeat (3) @(negedge clk);
        // R14 reset state
        check("R14 status", {24'd0, status}, 32'd0);
        check("R14 hold", {31'd0, hold}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [13:0] s;
            logic [6:0]  f;
            logic        ev;
            string       tg;
            s  = VEC[i][25:12];
            f  = VEC[i][11:5];
            tg = $sformatf("R%0d vec%0d", VEC[i][4:0], i);
            drive(s);
            @(negedge clk);
            // R12: event bit from flags and live stop/arb inputs
            ev = f[0] | f[2] | f[3] | f[6] | s[9] | s[5];
            check({tg, " R1 status"}, {24'd0, status}, {24'd0, ev, f});
            check({tg, " R12 irq"}, {31'd0, irq}, {31'd0, ev & s[12]});
            check({tg, " R13 hold"}, {31'd0, hold}, {31'd0, f[0] | f[2] | f[3]});
        end
        // R14: reset mid-run clears flags and arming
        drive(14'b11_000_000_00_100_0);
        @(negedge clk);
        rst_n = 1'b0;
        drive('0);
        @(negedge clk);
        check("R14 mid reset", {24'd0, status}, 32'd0);
        rst_n = 1'b1;
        drive(14'b11_100_000_00_000_0);
        @(negedge clk);
        drive(14'b11_000_000_00_001_0);
        @(negedge clk);
        check("R14 no arm after reset", {24'd0, status}, 32'h83);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule